// File: doc/BRIEF.md
# Relay Output Register File

This block is the register decoder and storage for a 64-channel relay output card. It sits behind an already-qualified bus select. Each access gives a long-word index and four byte-lane selects. The lanes are big-endian: the byte at the lowest offset of a long word travels on data bits 31:24. Byte, 16-bit and 32-bit transfers are all just lane patterns. The block holds the coil command bits and a small control register. It also returns a fixed card identity byte and the sampled state of a second contact set on each relay, which lets software confirm that every relay followed its command.

The control register has three bits. One drives the fail lamp, and that bit is active low, so the lamp is lit after reset. The other two enable the coil drivers for the lower and upper halves of the channels. A disabled half drops its coils while the command bits are kept and can still be read back. The `NUM_CH` parameter builds the 32-channel variant. In that variant the upper command and contact bytes are still decoded, but they store nothing and read as zero.

Top module: `rly_regfile`

## Requirements
- R1: A read of byte offset 0x00 (long word 0, lane on bits 31:24) returns 0x1B. Byte offsets 0x01, 0x03 and 0x04–0x0F read as 0x00.
- R2: The control byte at offset 0x02 (long word 0, bits 15:8) stores bit 15 = lamp off, bit 14 = lower-half enable (channels 31–0) and bit 13 = upper-half enable (channels 63–32). `fail_led_on` is the inverse of bit 15. Bits 12:8 read as 0.
- R3: After reset, bits 15:13 are 0, so `fail_led_on`=1, both enables are 0, all coils are off and all command bytes read 0.
- R4: Command bytes sit at offsets 0x10–0x17. Offset 0x10+m holds channels 63−8m down to 56−8m, with the highest channel on the most significant bit. A read returns the value last written.
- R5: `coil_drv` equals the stored command bits ANDed with the enable of their half. Disabling a half does not change the stored bits.
- R6: Offsets 0x18–0x1F return `contact_fb` with the same channel ordering as the command bytes.
- R7: Writes to the identity byte, the contact bytes and the unused offsets complete but change no state.
- R8: A write updates only the bytes whose lane select is 1. A read returns 0x00 on every unselected lane.
- R9: `acc_rdata` is loaded on the clock edge that takes a read access and holds its value until the next read.
- R10: With `NUM_CH`=32, offsets 0x10–0x13 and 0x18–0x1B read as 0 and ignore writes, and `coil_drv[63:32]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| acc_valid | input | 1 | Access cycle for this card (select already qualified) |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 3 | Long-word index (byte offset bits 4:2) |
| acc_lanes | input | 4 | Byte-lane selects, bit 3 = bits 31:24 = lowest byte offset |
| acc_wdata | input | 32 | Write data |
| contact_fb | input | 64 | Feedback contact state per channel |
| acc_rdata | output | 32 | Registered read data |
| coil_drv | output | 64 | Gated coil command per channel |
| fail_led_on | output | 1 | 1 = fail lamp lit |
| drv_en_lo | output | 1 | Driver enable, channels 31–0 |
| drv_en_hi | output | 1 | Driver enable, channels 63–32 |

## Verification
Command long words are written with asymmetric patterns such as 0xA5C30F81. These expose any byte swap or channel-order reversal between the write lane, the readback and the coil pins. Single-byte writes and partial-lane reads separate correct lane steering from whole-word updates. Enabling only one half at a time tells driver gating apart from loss of the stored command bits. A wide and a narrow instance receive the same traffic, so any stray storage in the upper bytes of the 32-channel variant shows up as a mismatch.

// File: rtl/rly_pkg.sv
package rly_pkg;
  localparam logic [7:0] CARD_ID      = 8'h1B;
  localparam logic [4:0] OFS_ID       = 5'h00;
  localparam logic [4:0] OFS_CTL      = 5'h02;
  localparam logic [1:0] WIN_CMD      = 2'b10;  // offsets 0x10-0x17
  localparam logic [1:0] WIN_FB       = 2'b11;  // offsets 0x18-0x1F

  // lane carrying byte j of a long word (big-endian)
  function automatic logic [1:0] lane_of(input logic [1:0] j);
    return 2'd3 - j;
  endfunction

  // channel byte index (0 = channels 7..0) for an offset in a 8-byte window
  function automatic logic [2:0] chan_byte(input logic [4:0] ofs);
    return 3'd7 - ofs[2:0];
  endfunction

  // window selector: offset bits 4:3
  function automatic logic [1:0] win_of(input logic [4:0] ofs);
    return ofs[4:3];
  endfunction
endpackage

// File: rtl/rly_lane_decode.sv
module rly_lane_decode
  import rly_pkg::*;
(
  input  logic        acc_valid,
  input  logic        acc_wr,
  input  logic [2:0]  acc_word,
  input  logic [3:0]  acc_lanes,
  output logic [31:0] wr_stb,
  output logic        rd_take
);
  for (genvar b = 0; b < 32; b++) begin : g_byte
    localparam logic [4:0] OFS = 5'(b);
    assign wr_stb[b] = acc_valid && acc_wr && (acc_word == OFS[4:2])
                       && acc_lanes[lane_of(OFS[1:0])];
  end
  assign rd_take = acc_valid && !acc_wr;
endmodule

// File: rtl/rly_ctl_reg.sv
module rly_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wbyte,
  output logic [2:0] ctl_bits,
  output logic       fail_led_on,
  output logic       drv_en_lo,
  output logic       drv_en_hi
);
  logic [2:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctl_q <= 3'b000;
    else if (we) ctl_q <= wbyte[7:5];
  end

  assign ctl_bits    = ctl_q;
  assign fail_led_on = !ctl_q[2];
  assign drv_en_lo   = ctl_q[1];
  assign drv_en_hi   = ctl_q[0];

  // R2: control bits move only on a control-byte write
  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q));
  // R3: first cycle out of reset shows lamp lit, drivers off
  p_reset_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (fail_led_on && !drv_en_lo && !drv_en_hi));
endmodule

// File: rtl/rly_cmd_bank.sv
module rly_cmd_bank #(
  parameter int NUM_CH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  wr_m,      // strobe per command offset 0x10+m
  input  logic [31:0] wdata,
  input  logic        en_lo,
  input  logic        en_hi,
  output logic [63:0] cmd_q,
  output logic [63:0] coil
);
  localparam int NUM_BYTES = NUM_CH / 8;
  localparam int HALF      = 32;

  for (genvar m = 0; m < 8; m++) begin : g_cmd
    localparam int K    = 7 - m;
    localparam int LANE = 3 - (m % 4);
    if (K < NUM_BYTES) begin : g_store
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       byte_q <= 8'h00;
        else if (wr_m[m]) byte_q <= wdata[8*LANE +: 8];
      end
      assign cmd_q[8*K +: 8] = byte_q;
    end else begin : g_absent
      assign cmd_q[8*K +: 8] = 8'h00;
    end
  end

  assign coil[HALF-1:0]  = cmd_q[HALF-1:0]  & {HALF{en_lo}};
  assign coil[63:HALF]   = cmd_q[63:HALF]   & {HALF{en_hi}};

  // R7: command storage changes only under a command-byte strobe
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_m) |=> $stable(cmd_q));
  // R10: narrow build never holds upper command bits
  if (NUM_BYTES < 8) begin : g_narrow_chk
    p_narrow_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      |wr_m[3:0] |=> (cmd_q[63:32] == 32'h0));
  end
endmodule

// File: rtl/rly_regfile.sv
module rly_regfile
  import rly_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_wr,
  input  logic [2:0]  acc_word,
  input  logic [3:0]  acc_lanes,
  input  logic [31:0] acc_wdata,
  input  logic [63:0] contact_fb,
  output logic [31:0] acc_rdata,
  output logic [63:0] coil_drv,
  output logic        fail_led_on,
  output logic        drv_en_lo,
  output logic        drv_en_hi
);
  localparam logic [63:0] CH_MASK = (NUM_CH >= 64) ? {64{1'b1}} : {32'h0, 32'hFFFF_FFFF};

  logic [31:0] wr_stb;
  logic        rd_take;
  logic [2:0]  ctl_bits;
  logic [63:0] cmd_q;
  logic [63:0] fb_eff;
  logic [31:0] rd_word;
  logic [31:0] rdata_q;

  rly_lane_decode i_dec (
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_word  (acc_word),
    .acc_lanes (acc_lanes),
    .wr_stb    (wr_stb),
    .rd_take   (rd_take)
  );

  rly_ctl_reg i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (wr_stb[OFS_CTL]),
    .wbyte       (acc_wdata[15:8]),
    .ctl_bits    (ctl_bits),
    .fail_led_on (fail_led_on),
    .drv_en_lo   (drv_en_lo),
    .drv_en_hi   (drv_en_hi)
  );

  rly_cmd_bank #(.NUM_CH(NUM_CH)) i_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_m  (wr_stb[23:16]),
    .wdata (acc_wdata),
    .en_lo (drv_en_lo),
    .en_hi (drv_en_hi),
    .cmd_q (cmd_q),
    .coil  (coil_drv)
  );

  assign fb_eff = contact_fb & CH_MASK;

  function automatic logic [7:0] byte_val(input logic [4:0] ofs, input logic [2:0] ctl,
                                          input logic [63:0] cmd, input logic [63:0] fb);
    logic [2:0] k;
    k = chan_byte(ofs);
    if (ofs == OFS_ID)          return CARD_ID;
    if (ofs == OFS_CTL)         return {ctl, 5'b0};
    if (win_of(ofs) == WIN_CMD) return cmd[{k, 3'b000} +: 8];
    if (win_of(ofs) == WIN_FB)  return fb[{k, 3'b000} +: 8];
    return 8'h00;
  endfunction

  always_comb begin
    rd_word = 32'h0;
    for (int j = 0; j < 4; j++) begin
      if (acc_lanes[lane_of(2'(j))])
        rd_word[8*lane_of(2'(j)) +: 8] = byte_val({acc_word, 2'(j)}, ctl_bits, cmd_q, fb_eff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= 32'h0;
    else if (rd_take) rdata_q <= rd_word;
  end
  assign acc_rdata = rdata_q;

  // R9: read data holds between read accesses
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> $stable(acc_rdata));
  // R1: identity lane read returns the card code
  p_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && acc_word == 3'd0 && acc_lanes[3]) |=> (acc_rdata[31:24] == CARD_ID));
  // R5: a disabled half never drives coils
  p_gate_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_lo |-> (coil_drv[31:0] == 32'h0));
  p_gate_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_hi |-> (coil_drv[63:32] == 32'h0));
  // R8: unselected lanes read as zero
  p_lane_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !acc_lanes[0]) |=> (acc_rdata[7:0] == 8'h00));
endmodule

// File: tb/test_rly_regfile.sv
module test_rly_regfile;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_wr = 1'b0;
  logic [2:0]  acc_word = '0;
  logic [3:0]  acc_lanes = '0;
  logic [31:0] acc_wdata = '0;
  logic [63:0] contact_fb = '0;
  logic [31:0] rdata_w, rdata_n;
  logic [63:0] coil_w, coil_n;
  logic        led_w, led_n, elo_w, elo_n, ehi_w, ehi_n;

  rly_regfile #(.NUM_CH(64)) i_rly_regfile (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_word(acc_word), .acc_lanes(acc_lanes), .acc_wdata(acc_wdata),
    .contact_fb(contact_fb), .acc_rdata(rdata_w), .coil_drv(coil_w),
    .fail_led_on(led_w), .drv_en_lo(elo_w), .drv_en_hi(ehi_w));

  rly_regfile #(.NUM_CH(32)) i_rly_regfile_n (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_word(acc_word), .acc_lanes(acc_lanes), .acc_wdata(acc_wdata),
    .contact_fb(contact_fb), .acc_rdata(rdata_n), .coil_drv(coil_n),
    .fail_led_on(led_n), .drv_en_lo(elo_n), .drv_en_hi(ehi_n));

  int total = 0, bad = 0;
  bit done = 0;
  typedef struct { logic [31:0] ew; logic [31:0] en; string tag; } exp_t;
  exp_t sbq[$];
  bit pend = 0;

  logic [63:0] cmd_w_m = '0, cmd_n_m = '0;
  logic [2:0]  ctl_m = '0;

  function automatic logic [7:0] mdl_byte(bit narrow, int o);
    int hi;
    if (o == 0) return 8'h1B;
    if (o == 2) return {ctl_m, 5'b00000};
    if (o >= 16 && o <= 23) begin
      hi = 63 - 8 * (o - 16);
      if (narrow && hi > 31) return 8'h00;
      return narrow ? cmd_n_m[hi -: 8] : cmd_w_m[hi -: 8];
    end
    if (o >= 24) begin
      hi = 63 - 8 * (o - 24);
      if (narrow && hi > 31) return 8'h00;
      return contact_fb[hi -: 8];
    end
    return 8'h00;
  endfunction

  function automatic logic [31:0] mdl_word(bit narrow, int w, logic [3:0] ln);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++)
      if (ln[3 - j]) r[31 - 8 * j -: 8] = mdl_byte(narrow, 4 * w + j);
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int w, logic [3:0] ln, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_wr = 1; acc_word = 3'(w); acc_lanes = ln; acc_wdata = d;
    for (int j = 0; j < 4; j++) begin
      if (ln[3 - j]) begin
        int o = 4 * w + j;
        logic [7:0] b = d[31 - 8 * j -: 8];
        if (o == 2) ctl_m = b[7:5];
        if (o >= 16 && o <= 23) begin
          int hi = 63 - 8 * (o - 16);
          cmd_w_m[hi -: 8] = b;
          if (hi < 32) cmd_n_m[hi -: 8] = b;
        end
      end
    end
    @(negedge clk);
    acc_valid = 0; acc_wr = 0;
  endtask

  task automatic bus_rd(int w, logic [3:0] ln, string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1; acc_wr = 0; acc_word = 3'(w); acc_lanes = ln;
    e.ew = mdl_word(0, w, ln); e.en = mdl_word(1, w, ln); e.tag = tag;
    sbq.push_back(e);
    @(posedge clk);
    #1 pend = 1;
    @(negedge clk);
    acc_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      pend = 0;
      e = sbq.pop_front();
      chk({e.tag, " wide"}, {32'h0, rdata_w}, {32'h0, e.ew});
      chk({e.tag, " narrow"}, {32'h0, rdata_n}, {32'h0, e.en});
    end
  end

  function automatic logic [63:0] gated(logic [63:0] c);
    return {c[63:32] & {32{ctl_m[0]}}, c[31:0] & {32{ctl_m[1]}}};
  endfunction

  task automatic chk_outs(string tag);
    chk({tag, " coil wide"}, coil_w, gated(cmd_w_m));
    chk({tag, " coil narrow"}, coil_n, gated(cmd_n_m));
    chk({tag, " led/en"}, {61'h0, led_w, elo_w, ehi_w}, {61'h0, !ctl_m[2], ctl_m[1], ctl_m[0]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3: reset state
    chk_outs("R3 reset");
    chk("R3 lamp lit", {63'h0, led_w}, 64'h1);
    bus_rd(0, 4'b1111, "R1 R3 id/ctl after reset");
    bus_rd(4, 4'b1111, "R3 cmd zero after reset");
    // R2/R7: all-ones to word 0 sets control, identity unchanged
    bus_wr(0, 4'b1111, 32'hFFFF_FFFF);
    chk_outs("R2 ctl all on");
    bus_rd(0, 4'b1111, "R2 R7 word0 readback");
    // R4: command words with asymmetric patterns
    bus_wr(4, 4'b1111, 32'hA5C3_0F81);
    bus_wr(5, 4'b1111, 32'h1234_5678);
    chk_outs("R4 R10 coils");
    bus_rd(4, 4'b1111, "R4 R10 cmd upper");
    bus_rd(5, 4'b1111, "R4 cmd lower");
    // R8: single byte write and partial read
    bus_wr(5, 4'b0100, 32'h00EE_0000);
    bus_rd(5, 4'b1111, "R8 byte write");
    bus_rd(5, 4'b0011, "R8 partial lanes");
    bus_rd(0, 4'b0100, "R8 R1 reserved lane");
    // R5: only lower half enabled, lamp on
    bus_wr(0, 4'b0010, 32'h0000_4000);
    chk_outs("R5 lo only");
    bus_rd(4, 4'b1111, "R5 stored kept");
    bus_wr(0, 4'b0010, 32'h0000_2000);
    chk_outs("R5 hi only");
    // R6: contacts
    contact_fb = 64'h0123_4567_89AB_CDEF;
    bus_rd(6, 4'b1111, "R6 R10 fb upper");
    bus_rd(7, 4'b1111, "R6 fb lower");
    // R7: writes to contact, identity and unused offsets
    bus_wr(6, 4'b1111, 32'hDEAD_BEEF);
    bus_wr(1, 4'b1111, 32'hFFFF_FFFF);
    bus_wr(3, 4'b1111, 32'h5555_5555);
    bus_rd(1, 4'b1111, "R7 unused");
    bus_rd(3, 4'b1111, "R7 unused hi");
    bus_rd(6, 4'b1111, "R7 fb unwritable");
    bus_rd(4, 4'b1111, "R7 cmd untouched");
    bus_rd(5, 4'b1111, "R7 cmd untouched lo");
    // R10: writes to narrow-absent bytes
    bus_wr(4, 4'b1000, 32'h7700_0000);
    bus_rd(4, 4'b1111, "R10 absent byte");
    // R9: read data holds with no read
    bus_rd(7, 4'b1111, "R9 setup");
    @(negedge clk);
    held = mdl_word(0, 7, 4'b1111);
    contact_fb = 64'hFFFF_0000_FFFF_0000;
    repeat (3) @(negedge clk);
    chk("R9 hold", {32'h0, rdata_w}, {32'h0, held});
    bus_wr(5, 4'b1111, 32'h0);
    chk("R9 hold after write", {32'h0, rdata_w}, {32'h0, held});
    // R3: reset mid-run
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cmd_w_m = '0; cmd_n_m = '0; ctl_m = '0;
    @(negedge clk);
    chk_outs("R3 re-reset");
    bus_rd(4, 4'b1111, "R3 cmd cleared");
    bus_rd(0, 4'b1111, "R3 ctl cleared");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule